// File: doc/BRIEF.md
# Approximate Triple-Copy Voter with Fault Detector

This block merges three redundant evaluations of the same multi-output combinational function into one protected result. One copy is exact. One is an under-approximation that may only turn a 1 into a 0 relative to the exact copy. One is an over-approximation that may only turn a 0 into a 1. Every output bit is majority-voted. Since at most one approximation is wrong for any input vector, the vote equals the exact result whenever no copy is faulty. A fault confined to a single copy is either masked by the vote or reported.

The voter knows which copy is which, so it can use the bitwise ordering under ≤ exact ≤ over to find two patterns that a healthy system cannot produce. The first is both approximations agreeing with each other while disagreeing with the exact copy. The second is the under copy high while the over copy is low. Either pattern raises a per-bit detect flag. Any flagged bit in a sampled cycle also sets a sticky error flag, which stays set until software-independent clear logic pulses a clear input. The result, the detect vector and the flag are registered one cycle after a valid strobe.

Top module: `atmr_voter`

## Requirements
- R1: One clock edge after a cycle with `in_valid` high, bit i of `voted_o` equals the majority of bit i of `exact_i`, `under_i` and `over_i`.
- R2: When the inputs satisfy `under_i` ≤ `exact_i` ≤ `over_i` bitwise, `voted_o` equals `exact_i` and `detect_o` is all zeros.
- R3: When one copy is corrupted on any number of bits (a multi-bit upset confined to one copy), `voted_o` still equals the fault-free exact value at every bit where the fault-free under and over copies agree.
- R4: A corruption confined to the under or the over copy is, at every bit, either masked (voted bit equals the fault-free exact bit) or reported by the detect bit of that position.
- R5: Bit i of `detect_o` is 1 when `under_i[i]` equals `over_i[i]` and both differ from `exact_i[i]`.
- R6: With `ORDER_CHECK` = 1 (the default), bit i of `detect_o` is also 1 when `under_i[i]` = 1 and `over_i[i]` = 0. Otherwise it is 0.
- R7: `err_o` becomes 1 one edge after a valid cycle that produces any detect bit. It holds until a cycle with `err_clr` high and no new detection. A new detection in the same cycle as `err_clr` wins, and the flag stays 1.
- R8: In cycles with `in_valid` low, `voted_o` and `detect_o` keep their values, `err_o` does not change except through `err_clr`, and `voted_valid_o` is 0 on the next edge.
- R9: A synchronous, active-high `rst` clears `voted_o`, `detect_o`, `err_o` and `voted_valid_o` on the next edge. It takes priority over all other inputs.
- R10: `voted_valid_o` equals the `in_valid` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The three copies are sampled this cycle |
| exact_i | input | WIDTH | Output bus of the exact copy |
| under_i | input | WIDTH | Output bus of the under-approximation |
| over_i | input | WIDTH | Output bus of the over-approximation |
| err_clr | input | 1 | Clears the sticky error flag |
| voted_o | output | WIDTH | Registered bitwise majority |
| detect_o | output | WIDTH | Registered per-bit detection flags |
| err_o | output | 1 | Sticky error flag |
| voted_valid_o | output | 1 | Outputs updated from a valid sample |

## Verification
On every cycle, the assertions check the following:
- An ordered input triple produces the exact value with no detection.
- Any detection sets the error flag, and the flag stays set without a clear.
- Idle cycles leave the registered result unchanged.
- The valid strobe is delayed by exactly one edge.

Only the bench scenarios can show the rest. The masking of corrupted copies needs a fault-free reference: single flips into each copy on random ordered vectors, plus multi-bit upsets in one copy. Only the scenarios can show whether a case was masked, detected, or (for exact-copy flips where the approximations disagree) legitimately lost. The same holds for the clear-versus-set race and for reset taking priority over a valid sample.

// File: rtl/atmr_pkg.sv
package atmr_pkg;

   // Result of voting one bit position.
   typedef struct packed {
      logic vote;
      logic det;
   } atmr_bit_t;

   function automatic logic atmr_maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/atmr_bit_cell.sv
module atmr_bit_cell
   import atmr_pkg::*;
#(
   parameter bit ORDER_CHECK = 1'b1
) (
   input  logic      ex,
   input  logic      un,
   input  logic      ov,
   output atmr_bit_t res
);

   // Both approximations agree with each other yet oppose the exact copy.
   logic agree_fault;
   assign agree_fault = ~(un ^ ov) & (un ^ ex);

   assign res.vote = atmr_maj3(ex, un, ov);

   generate
      if (ORDER_CHECK) begin : g_order
         // under above over breaks the ordering under <= exact <= over
         assign res.det = agree_fault | (un & ~ov);
      end else begin : g_no_order
         assign res.det = agree_fault;
      end
   endgenerate

endmodule

// File: rtl/atmr_vote_array.sv
module atmr_vote_array
   import atmr_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter bit ORDER_CHECK = 1'b1
) (
   input  logic [WIDTH-1:0] exact_d,
   input  logic [WIDTH-1:0] under_d,
   input  logic [WIDTH-1:0] over_d,
   output logic [WIDTH-1:0] vote_d,
   output logic [WIDTH-1:0] det_d
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("atmr_vote_array: WIDTH must be at least 1");
      end

      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         atmr_bit_t r;
         atmr_bit_cell #(.ORDER_CHECK(ORDER_CHECK)) u_cell (
            .ex  (exact_d[i]),
            .un  (under_d[i]),
            .ov  (over_d[i]),
            .res (r)
         );
         assign vote_d[i] = r.vote;
         assign det_d[i]  = r.det;
      end
   endgenerate

endmodule

// File: rtl/atmr_out_stage.sv
module atmr_out_stage #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] vote_d,
   input  logic [WIDTH-1:0] det_d,
   input  logic             err_clr,
   output logic [WIDTH-1:0] voted_q,
   output logic [WIDTH-1:0] detect_q,
   output logic             err_q,
   output logic             valid_q
);

   localparam logic [WIDTH-1:0] ZERO = '0;

   logic new_fault;
   assign new_fault = in_valid & (|det_d);

   always_ff @(posedge clk) begin
      if (rst) begin
         voted_q  <= ZERO;
         detect_q <= ZERO;
         err_q    <= 1'b0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) begin
            voted_q  <= vote_d;
            detect_q <= det_d;
         end
         // a fresh detection outranks the clear
         if (new_fault)    err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
      end
   end

   // R7: without a clear the flag cannot drop
   p_err_hold_r7: assert property (@(posedge clk) disable iff (rst)
      err_q && !err_clr |=> err_q);

   // R8: idle cycles keep the registered result
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(voted_q) && $stable(detect_q) && !valid_q);

endmodule

// File: rtl/atmr_voter.sv
module atmr_voter #(
   parameter int WIDTH       = 16,
   parameter bit ORDER_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] exact_i,
   input  logic [WIDTH-1:0] under_i,
   input  logic [WIDTH-1:0] over_i,
   input  logic             err_clr,
   output logic [WIDTH-1:0] voted_o,
   output logic [WIDTH-1:0] detect_o,
   output logic             err_o,
   output logic             voted_valid_o
);

   localparam logic [WIDTH-1:0] ZERO = '0;

   logic [WIDTH-1:0] vote_w;
   logic [WIDTH-1:0] det_w;

   atmr_vote_array #(.WIDTH(WIDTH), .ORDER_CHECK(ORDER_CHECK)) u_array (
      .exact_d (exact_i),
      .under_d (under_i),
      .over_d  (over_i),
      .vote_d  (vote_w),
      .det_d   (det_w)
   );

   atmr_out_stage #(.WIDTH(WIDTH)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .vote_d   (vote_w),
      .det_d    (det_w),
      .err_clr  (err_clr),
      .voted_q  (voted_o),
      .detect_q (detect_o),
      .err_q    (err_o),
      .valid_q  (voted_valid_o)
   );

   // R2: an ordered triple yields the exact copy and no detection
   p_ordered_exact_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid && ((under_i & ~exact_i) == ZERO) && ((exact_i & ~over_i) == ZERO)
      |=> (voted_o == $past(exact_i)) && (detect_o == ZERO));

   // R7: any detection in a sampled cycle raises the sticky flag
   p_err_set_r7: assert property (@(posedge clk) disable iff (rst)
      in_valid && (det_w != ZERO) |=> err_o);

   // R10: the valid strobe reaches the output one edge later
   p_valid_delay_r10: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> voted_valid_o);

endmodule

// File: tb/atmr_voter_test.sv
`timescale 1ns/1ps
module atmr_voter_test;

   localparam int W = 16;
   localparam int NROW = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [W-1:0] exact_i, under_i, over_i;
   logic         err_clr;
   logic [W-1:0] voted_o, detect_o;
   logic         err_o, voted_valid_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   atmr_voter #(.WIDTH(W)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .exact_i(exact_i), .under_i(under_i), .over_i(over_i),
      .err_clr(err_clr), .voted_o(voted_o), .detect_o(detect_o),
      .err_o(err_o), .voted_valid_o(voted_valid_o)
   );

   // row: {exact, under, over, expected vote, expected detect}
   localparam logic [5*W-1:0] TBL [NROW] = '{
      {16'hA5A5, 16'hA5A5, 16'hA5A5, 16'hA5A5, 16'h0000},  // R1 all agree
      {16'h00FF, 16'h000F, 16'h0FFF, 16'h00FF, 16'h0000},  // R2 ordered, approximations wrong
      {16'h00FE, 16'h000F, 16'h0FFF, 16'h00FF, 16'h0001},  // R5 exact flipped
      {16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h0001},  // R6 under above over
      {16'hFF00, 16'hFF00, 16'hFF01, 16'hFF00, 16'h0000},  // R2 over raised
      {16'h00F0, 16'h0000, 16'h00E0, 16'h00E0, 16'h0010},  // R4 over dropped, detected
      {16'hC3C3, 16'h3C3C, 16'h3C3C, 16'h3C3C, 16'hFFFF},  // R3 multi-bit upset in exact
      {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000}   // R1 all ones
   };

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at a falling edge, sample at the next falling edge
   task automatic step(input logic [W-1:0] g, input logic [W-1:0] f, input logic [W-1:0] h,
                       input logic v, input logic c);
      @(negedge clk);
      exact_i = g; under_i = f; over_i = h; in_valid = v; err_clr = c;
      @(negedge clk);
   endtask

   function automatic logic [W-1:0] mvote(input logic [W-1:0] g, f, h);
      return (g & f) | (g & h) | (f & h);
   endfunction

   function automatic logic [W-1:0] mdet(input logic [W-1:0] g, f, h);
      return (~(f ^ h) & (f ^ g)) | (f & ~h);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; err_clr = 1'b0;
      exact_i = '0; under_i = '0; over_i = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 reset voted", voted_o, '0);
      chk("R9 reset detect", detect_o, '0);
      chk("R9 reset err", {15'd0, err_o}, '0);
      chk("R9 reset valid", {15'd0, voted_valid_o}, '0);
      rst = 1'b0;

      // table walk; clear every row, so err follows the row's detection (R7 set wins)
      for (int i = 0; i < NROW; i++) begin
         logic [5*W-1:0] row;
         row = TBL[i];
         step(row[5*W-1:4*W], row[4*W-1:3*W], row[3*W-1:2*W], 1'b1, 1'b1);
         chk($sformatf("R1 row%0d vote", i), voted_o, row[2*W-1:W]);
         chk($sformatf("R5 R6 row%0d detect", i), detect_o, row[W-1:0]);
         chk($sformatf("R7 row%0d err", i), {15'd0, err_o}, {15'd0, row[W-1:0] != '0});
         chk($sformatf("R10 row%0d valid", i), {15'd0, voted_valid_o}, 16'd1);
      end

      // R8 idle hold: last row left FFFF / 0000
      step(16'h1234, 16'h4321, 16'h0000, 1'b0, 1'b0);
      chk("R8 idle vote", voted_o, 16'hFFFF);
      chk("R8 idle detect", detect_o, 16'h0000);
      chk("R8 idle valid", {15'd0, voted_valid_o}, 16'd0);

      // R7 sticky: set, idle, then clear
      step(16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0);
      step(16'h0001, 16'h0000, 16'h0000, 1'b1, 1'b0);
      chk("R7 set", {15'd0, err_o}, 16'd1);
      step(16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0);
      step(16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);
      chk("R7 held", {15'd0, err_o}, 16'd1);
      step(16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1);
      chk("R7 cleared", {15'd0, err_o}, 16'd0);

      // R9 reset outranks a valid, faulty sample
      step(16'h0001, 16'h0000, 16'h0000, 1'b1, 1'b0);
      chk("R7 set again", {15'd0, err_o}, 16'd1);
      @(negedge clk);
      rst = 1'b1; exact_i = 16'hFFFF; under_i = 16'h0000; over_i = 16'h0000; in_valid = 1'b1;
      @(negedge clk);
      chk("R9 midrun voted", voted_o, '0);
      chk("R9 midrun detect", detect_o, '0);
      chk("R9 midrun err", {15'd0, err_o}, '0);
      rst = 1'b0;

      // random single flips into each copy (R3, R4)
      for (int n = 0; n < 90; n++) begin
         logic [W-1:0] g0, f0, h0, g1, f1, h1, fl;
         int cp;
         g0 = W'($urandom);
         f0 = g0 & W'($urandom);
         h0 = g0 | W'($urandom);
         fl = W'(1) << ($urandom % W);
         cp = n % 3;
         g1 = (cp == 0) ? g0 ^ fl : g0;
         f1 = (cp == 1) ? f0 ^ fl : f0;
         h1 = (cp == 2) ? h0 ^ fl : h0;
         step(g1, f1, h1, 1'b1, 1'b1);
         chk($sformatf("R1 rand%0d vote", n), voted_o, mvote(g1, f1, h1));
         chk($sformatf("R5 R6 rand%0d detect", n), detect_o, mdet(g1, f1, h1));
         if (cp == 0)
            chk($sformatf("R3 rand%0d masked", n), (voted_o ^ g0) & ~(f0 ^ h0), '0);
         else
            chk($sformatf("R4 rand%0d masked or flagged", n), (voted_o ^ g0) & ~detect_o, '0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule